// File: doc/BRIEF.md
# Branch History Ring Buffer

This block keeps a short history of 64-bit branch records in a circular store of `DEPTH` slots. Each accepted push lands in the slot named by a write pointer and moves the pointer one step forward, wrapping at the end. The pointer therefore always names the oldest record, which is the next one to be overwritten. Software-facing logic reads the history by age rather than by slot: age 0 is the newest record, age 1 the one before it, and so on.

Reads and clears are commands that pass through an access gate first. A hypervisor facility enable covers every non-hypervisor access, and a separate user enable covers user-mode access. A command that fails the gate does not complete. Instead it produces a one-cycle fault pulse with a cause code and a flag that tells which level refused it. Accepted reads return data one cycle after the request. The data is forced to zero when the feature is off, when the history is frozen, or when the age is outside the store.

Top module: `brh_ring`

## Requirements
- R1: After reset the write pointer is slot 0, every entry is zero, and `rd_valid`, `rd_data`, `fault_pulse`, `fault_hv` and `fault_cause` are all zero. An accepted push writes its record at the pointer and advances the pointer by one, modulo `DEPTH`.
- R2: A read of age n that passes the gate sets `rd_valid` for exactly one cycle, one cycle after the request. Its `rd_data` is the entry at slot (pointer − n − 1) mod `DEPTH`, which is the n-th most recent record. This holds across pointer wrap.
- R3: While `feat_en` is low, accepted reads return zero and pushes are dropped.
- R4: An accepted read with `rd_index` ≥ `DEPTH` returns zero. `rd_index` is `IDX_W` bits wide.
- R5: While `freeze` is high, accepted reads return zero and pushes are dropped. When `freeze` falls, the earlier history is readable unchanged.
- R6: A clear that passes the gate while `feat_en` is high zeroes every entry and leaves the pointer where it is. If a push arrives in the same cycle, the clear wins. A clear while `feat_en` is low changes nothing.
- R7: A read or clear issued with `user_mode` high and `user_acc_en` low (and the hypervisor check passing) does not complete. One cycle later `fault_pulse` is 1 for one cycle, `fault_hv` is 0, `fault_cause` equals `FAULT_CAUSE`, and `rd_valid` stays 0.
- R8: A read or clear issued with `hv_mode` low and `hv_fac_en` low does not complete. One cycle later `fault_pulse` is 1, `fault_hv` is 1, `fault_cause` equals `FAULT_CAUSE`, and `rd_valid` stays 0. This check takes precedence over the user check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer a record for the history |
| push_data | input | DW | Record to store |
| rd_req | input | 1 | Read request by age |
| rd_index | input | IDX_W | Age of the record to read, 0 = newest |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted request |
| rd_data | output | DW | Read result, zero when not valid |
| clr_req | input | 1 | Clear command |
| feat_en | input | 1 | History feature enable |
| freeze | input | 1 | Freeze history: reads give zero, pushes dropped |
| user_mode | input | 1 | Requester is in user mode |
| user_acc_en | input | 1 | User access enable |
| hv_mode | input | 1 | Requester is in hypervisor mode |
| hv_fac_en | input | 1 | Hypervisor facility enable for lower levels |
| fault_pulse | output | 1 | One-cycle facility-unavailable fault |
| fault_hv | output | 1 | Fault came from the hypervisor check |
| fault_cause | output | 4 | Cause code during a fault, else zero |

## Verification
The bench builds the block with `DEPTH` = 8 and `IDX_W` = 5. With only eight slots, eleven pushes are enough to wrap the pointer and test age reads across the wrap boundary. The five-bit index reaches ages 8 to 31, which lie outside the store and must read as zero. `FAULT_CAUSE` keeps its default of 5, so the bench can recognise a real cause code as distinct from the idle zero.

// File: rtl/brh_pkg.sv
package brh_pkg;

   // Outcome of the access gate for a read or clear command
   typedef enum logic [1:0] {
      ACC_OK        = 2'd0,
      ACC_USR_FAULT = 2'd1,
      ACC_HV_FAULT  = 2'd2
   } acc_e;

endpackage

// File: rtl/brh_gate.sv
module brh_gate
   import brh_pkg::*;
(
   input  logic user_mode,
   input  logic user_acc_en,
   input  logic hv_mode,
   input  logic hv_fac_en,
   output acc_e verdict
);

   // Hypervisor facility check is evaluated first (R8), then user (R7)
   always_comb begin
      if (!hv_mode && !hv_fac_en)
         verdict = ACC_HV_FAULT;
      else if (user_mode && !user_acc_en)
         verdict = ACC_USR_FAULT;
      else
         verdict = ACC_OK;
   end

endmodule

// File: rtl/brh_store.sv
module brh_store #(
   parameter int DEPTH = 32,
   parameter int DW    = 64,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push_en,
   input  logic [DW-1:0]             push_data,
   input  logic                      clr_en,
   output logic [PW-1:0]             wp,
   output logic [DEPTH-1:0][DW-1:0]  entries
);

   // One register per slot; clear beats push
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            entries[g] <= '0;
         else if (clr_en)
            entries[g] <= '0;
         else if (push_en && (wp == PW'(g)))
            entries[g] <= push_data;
      end
   end

   // Write pointer: natural wrap since DEPTH is a power of two
   always_ff @(posedge clk) begin
      if (!rst_n)
         wp <= '0;
      else if (push_en && !clr_en)
         wp <= wp + PW'(1);
   end

   // R6: an accepted clear leaves every slot empty
   a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> (entries == '0));

   // R6: a clear never moves the pointer
   a_r6_clear_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> $stable(wp));

endmodule

// File: rtl/brh_read.sv
module brh_read #(
   parameter int DEPTH = 32,
   parameter int DW    = 64,
   parameter int IDX_W = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_fire,
   input  logic [IDX_W-1:0]          rd_index,
   input  logic                      force_zero,
   input  logic [PW-1:0]             wp,
   input  logic [DEPTH-1:0][DW-1:0]  entries,
   output logic                      rd_valid,
   output logic [DW-1:0]             rd_data
);

   logic [PW-1:0] slot;
   logic          out_of_range;

   // Age n lives one step behind the pointer, minus n
   assign slot         = wp - rd_index[PW-1:0] - PW'(1);
   assign out_of_range = (rd_index >= IDX_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire && !force_zero && !out_of_range)
            rd_data <= entries[slot];
         else
            rd_data <= '0;
      end
   end

   // R4: ages outside the store read as zero
   a_r4_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && out_of_range) |=> (rd_valid && rd_data == '0));

   // R2: valid only follows an accepted request
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_fire));

endmodule

// File: rtl/brh_ring.sv
module brh_ring
   import brh_pkg::*;
#(
   parameter int         DEPTH       = 32,
   parameter int         DW          = 64,
   parameter int         IDX_W       = 8,
   parameter logic [3:0] FAULT_CAUSE = 4'd5,
   localparam int        PW          = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_valid,
   input  logic [DW-1:0]    push_data,
   input  logic             rd_req,
   input  logic [IDX_W-1:0] rd_index,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   input  logic             clr_req,
   input  logic             feat_en,
   input  logic             freeze,
   input  logic             user_mode,
   input  logic             user_acc_en,
   input  logic             hv_mode,
   input  logic             hv_fac_en,
   output logic             fault_pulse,
   output logic             fault_hv,
   output logic [3:0]       fault_cause
);

   // Elaboration-time parameter checks
   initial begin
      a_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two and at least 2");
      a_idx_wide: assert (IDX_W > PW)
         else $error("IDX_W must be able to express DEPTH");
      a_cause_nonzero: assert (FAULT_CAUSE != 4'd0)
         else $error("FAULT_CAUSE must differ from the idle value");
   end

   acc_e                     verdict;
   logic                     cmd, granted, push_en, clr_en, rd_fire;
   logic [PW-1:0]            wp;
   logic [DEPTH-1:0][DW-1:0] entries;

   brh_gate u_gate (
      .user_mode  (user_mode),
      .user_acc_en(user_acc_en),
      .hv_mode    (hv_mode),
      .hv_fac_en  (hv_fac_en),
      .verdict    (verdict)
   );

   assign cmd     = rd_req | clr_req;
   assign granted = (verdict == ACC_OK);
   assign push_en = push_valid & feat_en & ~freeze;
   assign clr_en  = clr_req & granted & feat_en;
   assign rd_fire = rd_req & granted;

   brh_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (push_en),
      .push_data(push_data),
      .clr_en   (clr_en),
      .wp       (wp),
      .entries  (entries)
   );

   brh_read #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (rd_fire),
      .rd_index  (rd_index),
      .force_zero(~feat_en | freeze),
      .wp        (wp),
      .entries   (entries),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   // Fault reporting, registered to line up with read data
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_pulse <= 1'b0;
         fault_hv    <= 1'b0;
         fault_cause <= '0;
      end else begin
         fault_pulse <= cmd & ~granted;
         fault_hv    <= cmd & (verdict == ACC_HV_FAULT);
         fault_cause <= (cmd & ~granted) ? FAULT_CAUSE : 4'd0;
      end
   end

   // R8: hypervisor refusal, with its flag and cause
   a_r8_hv_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd && !hv_mode && !hv_fac_en) |=>
         (fault_pulse && fault_hv && fault_cause == FAULT_CAUSE && !rd_valid));

   // R7: user refusal when the hypervisor check passes
   a_r7_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd && (hv_mode || hv_fac_en) && user_mode && !user_acc_en) |=>
         (fault_pulse && !fault_hv && fault_cause == FAULT_CAUSE && !rd_valid));

   // R5: a frozen push leaves the pointer alone
   a_r5_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && freeze) |=> $stable(wp));

   // R3: a push with the feature off leaves the pointer alone
   a_r3_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !feat_en) |=> $stable(wp));

   // R7: a fault and read data never appear together
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> !rd_valid);

endmodule

// File: tb/brh_ring_tb.sv
module brh_ring_tb;

   localparam int         DEPTH = 8;
   localparam int         DW    = 64;
   localparam int         IDX_W = 5;
   localparam logic [3:0] CAUSE = 4'd5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             push_valid = 1'b0;
   logic [DW-1:0]    push_data = '0;
   logic             rd_req = 1'b0;
   logic [IDX_W-1:0] rd_index = '0;
   logic             rd_valid;
   logic [DW-1:0]    rd_data;
   logic             clr_req = 1'b0;
   logic             feat_en = 1'b0;
   logic             freeze = 1'b0;
   logic             user_mode = 1'b0;
   logic             user_acc_en = 1'b0;
   logic             hv_mode = 1'b1;
   logic             hv_fac_en = 1'b1;
   logic             fault_pulse;
   logic             fault_hv;
   logic [3:0]       fault_cause;

   always #4 clk = ~clk;   // 125 MHz

   brh_ring #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W), .FAULT_CAUSE(CAUSE)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_data(push_data),
      .rd_req(rd_req), .rd_index(rd_index),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .clr_req(clr_req), .feat_en(feat_en), .freeze(freeze),
      .user_mode(user_mode), .user_acc_en(user_acc_en),
      .hv_mode(hv_mode), .hv_fac_en(hv_fac_en),
      .fault_pulse(fault_pulse), .fault_hv(fault_hv), .fault_cause(fault_cause)
   );

   typedef struct {
      int          due;
      logic        exp_valid;
      logic [63:0] exp_data;
      logic        exp_fault;
      logic        exp_hv;
      string       tag;
   } item_t;

   item_t       sb[$];
   int          checks = 0;
   int          fails = 0;
   int          cyc = 0;
   bit          done = 1'b0;
   logic [63:0] mem_m [DEPTH];
   int          wp_m = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare due items against the outputs
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rd_valid !== it.exp_valid || rd_data !== it.exp_data ||
                fault_pulse !== it.exp_fault || fault_hv !== it.exp_hv ||
                fault_cause !== (it.exp_fault ? CAUSE : 4'd0)) begin
               fails++;
               $display("FAIL %s: got v=%0b d=%h f=%0b hv=%0b c=%0d exp v=%0b d=%h f=%0b hv=%0b",
                        it.tag, rd_valid, rd_data, fault_pulse, fault_hv, fault_cause,
                        it.exp_valid, it.exp_data, it.exp_fault, it.exp_hv);
            end
         end else if (rd_valid || fault_pulse) begin
            checks++;
            fails++;
            $display("FAIL R2/R7 unexpected output: v=%0b f=%0b exp v=0 f=0", rd_valid, fault_pulse);
         end
      end
   end

   function automatic int verdict_m();
      if (!hv_mode && !hv_fac_en) return 2;
      if (user_mode && !user_acc_en) return 1;
      return 0;
   endfunction

   task automatic push_rec(input logic [63:0] d);
      @(negedge clk);
      push_valid = 1'b1;
      push_data  = d;
      if (feat_en && !freeze) begin
         mem_m[wp_m] = d;
         wp_m = (wp_m + 1) % DEPTH;
      end
      @(negedge clk);
      push_valid = 1'b0;
   endtask

   task automatic read_age(input int idx, input string tag);
      item_t it;
      int v;
      @(negedge clk);
      v = verdict_m();
      it.due = cyc + 1;
      it.tag = tag;
      it.exp_fault = (v != 0);
      it.exp_hv    = (v == 2);
      it.exp_valid = (v == 0);
      if (v != 0 || !feat_en || freeze || idx >= DEPTH)
         it.exp_data = '0;
      else
         it.exp_data = mem_m[(wp_m - idx - 1 + DEPTH) % DEPTH];
      sb.push_back(it);
      rd_req   = 1'b1;
      rd_index = IDX_W'(idx);
      @(negedge clk);
      rd_req = 1'b0;
   endtask

   task automatic clear_all(input string tag);
      item_t it;
      int v;
      @(negedge clk);
      v = verdict_m();
      if (v != 0) begin
         it.due = cyc + 1;
         it.tag = tag;
         it.exp_fault = 1'b1;
         it.exp_hv    = (v == 2);
         it.exp_valid = 1'b0;
         it.exp_data  = '0;
         sb.push_back(it);
      end else if (feat_en) begin
         for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      end
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
   endtask

   task automatic read_all(input string tag);
      for (int i = 0; i < DEPTH; i++) read_age(i, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, exp completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (rd_valid !== 1'b0 || rd_data !== '0 || fault_pulse !== 1'b0 ||
          fault_hv !== 1'b0 || fault_cause !== 4'd0) begin
         fails++;
         $display("FAIL R1 reset outputs: v=%0b d=%h f=%0b exp all zero", rd_valid, rd_data, fault_pulse);
      end
      feat_en = 1'b1;
      read_age(0, "R1 empty entry after reset");

      // R2: basic age ordering
      for (int i = 0; i < 5; i++) push_rec(64'hA5A5_0000_0000_0010 + 64'(i));
      for (int i = 0; i < 6; i++) read_age(i, "R2 age read");

      // R1/R2: wrap the pointer
      for (int i = 0; i < 6; i++) push_rec(64'h5A5A_1111_0000_0000 ^ (64'(i) << 32));
      read_all("R2 age read across wrap R1");

      // R4: ages beyond the store
      read_age(8, "R4 index equal to depth");
      read_age(31, "R4 index maximum");

      // R5: freeze
      freeze = 1'b1;
      read_age(0, "R5 read while frozen");
      push_rec(64'hDEAD_0000_0000_0001);
      freeze = 1'b0;
      read_age(0, "R5 history intact after freeze");
      read_age(1, "R5 history intact after freeze");

      // R3/R6: feature off
      feat_en = 1'b0;
      read_age(0, "R3 read with feature off");
      push_rec(64'hDEAD_0000_0000_0002);
      clear_all("R6 clear with feature off");
      feat_en = 1'b1;
      read_all("R3/R6 history intact after feature off");

      // R7: user access gate
      user_mode = 1'b1;
      read_age(0, "R7 user read refused");
      clear_all("R7 user clear refused");
      user_acc_en = 1'b1;
      read_age(0, "R7 user read allowed");
      user_acc_en = 1'b0;

      // R8: hypervisor gate, precedence over user gate
      hv_mode = 1'b0; hv_fac_en = 1'b0;
      read_age(2, "R8 hv read refused over user");
      user_mode = 1'b0;
      clear_all("R8 hv clear refused");
      hv_fac_en = 1'b1;
      read_age(2, "R8 read allowed with facility on");
      hv_mode = 1'b1; hv_fac_en = 1'b0;
      read_all("R8 history intact after refused clears");

      // R6: accepted clear, pointer kept
      clear_all("R6 clear accepted");
      read_all("R6 entries zero after clear");
      push_rec(64'h0123_4567_89AB_CDEF);
      read_age(0, "R6 push after clear newest");
      read_age(1, "R6 push after clear older zero");

      // R6: clear beats a push in the same cycle
      @(negedge clk);
      push_valid = 1'b1;
      push_data  = 64'hFFFF_0000_FFFF_0000;
      clr_req    = 1'b1;
      for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      @(negedge clk);
      push_valid = 1'b0;
      clr_req    = 1'b0;
      read_all("R6 clear wins over push");

      repeat (4) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R2 pending results: got %0d exp 0", sb.size());
      end
      finish_run();
   end

endmodule